// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block ranks up to 256 interrupt vectors for a single processor. Vector-set pulses record requests, together with the trigger mode of each vector. The block keeps three state sets: pending requests, vectors in service and trigger mode. It compares priority by 16-vector class. The current processor priority comes from two sources: a programmed task priority and the class of the highest vector still in service.

The core sees a registered pending level. When the core takes an interrupt it sends an acknowledge strobe. The block answers one cycle later with the granted vector and its trigger mode. If the task priority blocks the request, the answer is the programmed spurious vector. When the handler finishes, an end-of-interrupt strobe retires the highest vector in service. A software-enable bit in the spurious register gates both the pending line and the acknowledge.

Top module: `vipc_top`

## Requirements
- R1: After reset, `irq_pending` is 0 and `ppr_out` is 0. The block is disabled (spurious register = 0x0FF, bit 8 clear), so an acknowledge gives `ack_valid` = 0.
- R2: A set pulse marks its vector as requested. `set_level` = 1 records level trigger and 0 records edge trigger. A later set of the same vector overwrites the mode. The mode is reported on `ack_level` when that vector is granted.
- R3: When several requests are pending, an acknowledge grants the highest-numbered one.
- R4: `ppr_out` equals the task priority when taskpri[7:4] is at least the in-service class (highest in-service vector >> 4, or 0 when none). Otherwise it equals that class << 4.
- R5: The registered `irq_pending` is 1 exactly when three conditions hold in the previous cycle: the block is enabled, a request exists, and either `ppr_out` is 0 or the request's class [7:4] is greater than the class of `ppr_out`.
- R6: An acknowledge is blocked when task priority is nonzero and the highest request is less than or equal to task priority (8-bit compare). A blocked acknowledge returns `ack_valid` = 1 with the spurious register's low byte and leaves all requests unchanged.
- R7: A granted acknowledge returns the vector number one cycle later, clears its request bit and marks it in service.
- R8: An end-of-interrupt clears the highest in-service vector, if any.
- R9: While spurious bit 8 is 0, `irq_pending` stays 0 and an acknowledge returns `ack_valid` = 0 with no state change. Requests set meanwhile are kept.
- R10: Only bits [8:0] of a spurious-register write are stored. Bits [15:9] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_valid | input | 1 | Vector-set pulse |
| set_vector | input | 8 | Vector number to request |
| set_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack | input | 1 | Acknowledge strobe from the core |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write enable |
| tpr_wdata | input | 8 | Task-priority write data |
| svr_we | input | 1 | Spurious-register write enable |
| svr_wdata | input | 16 | Spurious-register write data, bits [8:0] kept |
| irq_pending | output | 1 | Registered pending-interrupt level |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Granted vector or spurious vector |
| ack_level | output | 1 | Trigger mode of the granted vector |
| ppr_out | output | 8 | Current processor priority |

## Verification
Requests are spread across different classes (0x21, 0x8F, 0x90). This shows that the grant order follows the vector number and not arrival order, and that the group boundary of the leading-one search is crossed correctly. The in-service priority is then unwound by repeated end-of-interrupt strobes, which tells apart retiring the highest vector from retiring any other. Task-priority values are chosen to fall below, equal to and above the request class, and to give a zero processor priority. These separate the class compare of the pending line from the full-byte compare that blocks an acknowledge. Disable/re-enable and level/edge overwrite patterns show that gating hides requests without losing them.

// File: rtl/vipc_pkg.sv
package vipc_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int GRP_W   = 32;
  localparam int SVR_W   = 9;
  localparam int CLS_LSB = 4;

  // Priority class of an 8-bit vector/priority value
  function automatic logic [VEC_W-CLS_LSB-1:0] cls_of(input logic [VEC_W-1:0] v);
    return v[VEC_W-1:CLS_LSB];
  endfunction

  // Processor priority from task priority and highest in-service vector
  function automatic logic [VEC_W-1:0] calc_ppr(input logic [VEC_W-1:0] tpr,
                                                input logic             isr_vld,
                                                input logic [VEC_W-1:0] isr_top);
    logic [VEC_W-CLS_LSB-1:0] c;
    c = isr_vld ? cls_of(isr_top) : '0;
    if (cls_of(tpr) >= c) return tpr;
    return {c, {CLS_LSB{1'b0}}};
  endfunction

  // Request outranks processor priority
  function automatic logic pend_ok(input logic [VEC_W-1:0] req,
                                   input logic [VEC_W-1:0] ppr);
    return (ppr == '0) || (cls_of(req) > cls_of(ppr));
  endfunction
endpackage

// File: rtl/vipc_lod.sv
module vipc_lod #(
  parameter int N  = vipc_pkg::NUM_VEC,
  parameter int G  = vipc_pkg::GRP_W,
  localparam int IW = $clog2(N),
  localparam int GW = $clog2(G),
  localparam int NG = N / G
) (
  input  logic [N-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic          vld
);
  logic [NG-1:0] grp_vld;
  logic [GW-1:0] grp_idx [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_comb begin
      grp_idx[g] = '0;
      for (int b = 0; b < G; b++)
        if (bits[g*G + b]) grp_idx[g] = GW'(b);
    end
    assign grp_vld[g] = |bits[g*G +: G];
  end

  always_comb begin
    idx = '0;
    for (int g = 0; g < NG; g++)
      if (grp_vld[g]) idx = IW'(g * G) + IW'(grp_idx[g]);
  end
  assign vld = |grp_vld;
endmodule

// File: rtl/vipc_cfg.sv
module vipc_cfg #(
  parameter int VW = vipc_pkg::VEC_W,
  parameter int SW = vipc_pkg::SVR_W,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tpr_we,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          svr_we,
  input  logic [WW-1:0] svr_wdata,
  output logic [VW-1:0] tpr,
  output logic [SW-1:0] svr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr <= '0;
      svr <= SW'({VW{1'b1}});
    end else begin
      if (tpr_we) tpr <= tpr_wdata;
      if (svr_we) svr <= svr_wdata[SW-1:0];
    end
  end

  p_svr_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    svr_we |=> svr == $past(svr_wdata[SW-1:0]));
endmodule

// File: rtl/vipc_top.sv
module vipc_top
  import vipc_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int GW = GRP_W,
  localparam int NV = 1 << VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_valid,
  input  logic [VW-1:0] set_vector,
  input  logic          set_level,
  input  logic          ack,
  input  logic          eoi,
  input  logic          tpr_we,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          svr_we,
  input  logic [15:0]   svr_wdata,
  output logic          irq_pending,
  output logic          ack_valid,
  output logic [VW-1:0] ack_vector,
  output logic          ack_level,
  output logic [VW-1:0] ppr_out
);
  logic [NV-1:0] irr_q, isr_q, tmr_q, irr_n, isr_n, tmr_n;
  logic [VW-1:0] irr_top, isr_top, tpr;
  logic          irr_vld, isr_vld;
  logic [SVR_W-1:0] svr;
  logic          enable, ack_block, ack_grant, eoi_hit;

  vipc_cfg #(.VW(VW), .SW(SVR_W), .WW(16)) u_cfg (
    .clk, .rst_n, .tpr_we, .tpr_wdata, .svr_we, .svr_wdata, .tpr, .svr);

  vipc_lod #(.N(NV), .G(GW)) u_irr_lod (.bits(irr_q), .idx(irr_top), .vld(irr_vld));
  vipc_lod #(.N(NV), .G(GW)) u_isr_lod (.bits(isr_q), .idx(isr_top), .vld(isr_vld));

  assign enable    = svr[VW];
  assign ppr_out   = calc_ppr(tpr, isr_vld, isr_top);
  assign ack_block = ack && enable && irr_vld && (tpr != '0) && (irr_top <= tpr);
  assign ack_grant = ack && enable && irr_vld && !ack_block;
  assign eoi_hit   = eoi && isr_vld;

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (ack_grant) begin
      irr_n[irr_top] = 1'b0;
    end
    if (eoi_hit) isr_n[isr_top] = 1'b0;
    if (ack_grant) isr_n[irr_top] = 1'b1;
    if (set_valid) begin
      irr_n[set_vector] = 1'b1;
      tmr_n[set_vector] = set_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q       <= '0;
      isr_q       <= '0;
      tmr_q       <= '0;
      irq_pending <= 1'b0;
      ack_valid   <= 1'b0;
      ack_vector  <= '0;
      ack_level   <= 1'b0;
    end else begin
      irr_q       <= irr_n;
      isr_q       <= isr_n;
      tmr_q       <= tmr_n;
      irq_pending <= enable && irr_vld && pend_ok(irr_top, ppr_out);
      ack_valid   <= ack_grant || ack_block;
      ack_vector  <= ack_grant ? irr_top : svr[VW-1:0];
      ack_level   <= ack_grant && tmr_q[irr_top];
    end
  end

  p_pend_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> $past(enable) && $past(irr_vld));
  p_ack_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !enable) |=> !ack_valid);
  p_grant_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_grant && !(set_valid && set_vector == irr_top))
      |=> !irr_q[$past(irr_top)] && isr_q[$past(irr_top)]);
  p_block_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_block && !set_valid) |=> irr_q == $past(irr_q) && ack_vector == $past(svr[VW-1:0]));
  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !ack_grant) |=> !isr_q[$past(isr_top)]);
  p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_out >= tpr);
endmodule

// File: tb/tb_vipc_top.sv
module tb_vipc_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic set_valid = 0, set_level = 0, ack = 0, eoi = 0, tpr_we = 0, svr_we = 0;
  logic [7:0] set_vector = 0, tpr_wdata = 0;
  logic [15:0] svr_wdata = 0;
  logic irq_pending, ack_valid, ack_level;
  logic [7:0] ack_vector, ppr_out;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  vipc_top dut (.clk, .rst_n, .set_valid, .set_vector, .set_level, .ack, .eoi,
    .tpr_we, .tpr_wdata, .svr_we, .svr_wdata, .irq_pending, .ack_valid,
    .ack_vector, .ack_level, .ppr_out);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_set(input logic [7:0] v, input logic lvl);
    @(negedge clk); set_valid = 1; set_vector = v; set_level = lvl;
    @(negedge clk); set_valid = 0;
  endtask
  task automatic do_tpr(input logic [7:0] v);
    @(negedge clk); tpr_we = 1; tpr_wdata = v;
    @(negedge clk); tpr_we = 0;
  endtask
  task automatic do_svr(input logic [15:0] v);
    @(negedge clk); svr_we = 1; svr_wdata = v;
    @(negedge clk); svr_we = 0;
  endtask
  task automatic do_eoi();
    @(negedge clk); eoi = 1;
    @(negedge clk); eoi = 0;
  endtask
  // Acknowledge and check the registered response
  task automatic do_ack(input string req, input logic vld, input logic [7:0] vec);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk({req, " ack_valid"}, ack_valid, vld);
    if (vld) chk({req, " ack_vector"}, ack_vector, vec);
  endtask
  task automatic chk_pend(input string req, input logic exp);
    @(negedge clk);
    chk({req, " irq_pending"}, irq_pending, exp);
  endtask

  task automatic t_reset();
    chk("R1 reset pending", irq_pending, 0);
    chk("R1 reset ppr", ppr_out, 0);
    do_set(8'h10, 0);
    chk_pend("R1 disabled after reset", 0);
    do_ack("R1 ack while disabled", 0, 0);
  endtask

  task automatic t_disabled();
    do_svr(16'hF13F);                      // bit8=1 enable, low byte 0x3F
    chk_pend("R9 request kept while disabled", 1);
    do_ack("R9 kept request granted", 1, 8'h10);
    do_eoi();
    do_svr(16'hFE33);                      // bit8=0 disable
    do_set(8'h80, 0);
    chk_pend("R9 pending gated", 0);
    do_ack("R9 ack gated", 0, 0);
    do_svr(16'hF13F);
    chk_pend("R9 re-enabled pending", 1);
    do_ack("R9 re-enabled grant", 1, 8'h80);
    do_eoi();
  endtask

  task automatic t_trigger();
    do_set(8'h45, 1);
    do_ack("R2 level grant", 1, 8'h45);
    chk("R2 level mode", ack_level, 1);
    do_eoi();
    do_set(8'h45, 1);
    do_set(8'h45, 0);
    do_ack("R2 edge overwrite grant", 1, 8'h45);
    chk("R2 edge mode", ack_level, 0);
    do_eoi();
  endtask

  task automatic t_order();
    do_set(8'h21, 0); do_set(8'h90, 0); do_set(8'h8F, 0);
    do_ack("R3 first", 1, 8'h90);
    chk("R4 ppr from isr 0x90", ppr_out, 8'h90);
    do_ack("R3 second", 1, 8'h8F);
    do_ack("R7 third", 1, 8'h21);
    do_ack("R7 irr emptied", 0, 0);
    do_eoi();
    chk("R8 ppr after first eoi", ppr_out, 8'h80);
    do_eoi();
    chk("R8 ppr after second eoi", ppr_out, 8'h20);
    do_eoi();
    chk("R8 ppr after last eoi", ppr_out, 8'h00);
  endtask

  task automatic t_ppr();
    do_tpr(8'h35);
    chk("R4 ppr equals tpr", ppr_out, 8'h35);
    do_set(8'h70, 0);
    do_ack("R4 grant above tpr", 1, 8'h70);
    chk("R4 ppr from isr class", ppr_out, 8'h70);
    do_tpr(8'h85);
    chk("R4 tpr class wins", ppr_out, 8'h85);
    do_eoi();
    do_tpr(8'h00);
    chk("R4 ppr cleared", ppr_out, 8'h00);
  endtask

  task automatic t_pending();
    do_set(8'h05, 0);
    chk_pend("R5 ppr zero passes class 0", 1);
    do_ack("R5 drain 0x05", 1, 8'h05);
    do_eoi();
    do_tpr(8'h50);
    do_set(8'h5A, 0);
    chk_pend("R5 equal class blocked", 0);
    do_set(8'h61, 0);
    chk_pend("R5 higher class pending", 1);
    do_ack("R5 grant 0x61", 1, 8'h61);
    chk_pend("R5 in-service masks 0x5A", 0);
    do_eoi();
    chk_pend("R5 tpr still masks 0x5A", 0);
    do_tpr(8'h5A);
    do_ack("R6 blocked ack spurious", 1, 8'h3F);
    do_tpr(8'h00);
    do_ack("R6 request survived block", 1, 8'h5A);
    do_eoi();
  endtask

  task automatic t_svr_width();
    do_svr(16'hFE33);
    do_set(8'h11, 0);
    chk_pend("R10 upper bits ignored, disabled", 0);
    do_svr(16'h0177);
    do_tpr(8'hF0);
    do_ack("R10 spurious low byte", 1, 8'h77);
    do_tpr(8'h00);
    do_ack("R10 drain", 1, 8'h11);
    do_eoi();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_trigger();
    t_order();
    t_ppr();
    t_pending();
    t_svr_width();
    summary();
  end
endmodule